// File: doc/BRIEF.md
# Boot ROM Read Overlay Unit

This block sits between the boot ROM and the cores that read it. Each read request carries an address, a flag telling an instruction fetch from a data read, and the number of the requesting core. The ROM supplies its word for the same request. When the overlay is globally enabled and the address falls inside one of two fixed 4 KB windows, the block can replace that ROM word. The replacement is chosen per core and per access type.

A data read can be given a programmable 32-bit word. An instruction fetch can be given the fixed encoding 0xE59FF000, which loads the PC from a PC-relative literal. The literal load that this instruction then performs is a data read into the same window. If the data override is also on, that read returns the programmed word, so the core branches to an address that software chose. This lets secondary cores be steered away from boot code they cannot run.

Configuration goes through a small write port with a combinational readback. The response to a request comes out one clock after the request.

Top module: `rom_overlay`

## Requirements
- R1: After reset, every configuration register reads back zero, and `rsp_valid` is low.
- R2: The control register is at config address 0. Bit 0 is the global enable. It reads back with bits 31:1 at zero whatever was written there.
- R3: The overlay word is at config address 1 and stores and reads back all 32 bits.
- R4: The boot register of core n is at config address 4+n. Bit 0 enables the fetch override and bit 1 enables the data override. Bits 31:2 read back zero. Config addresses 2 and 3 read zero and ignore writes.
- R5: A data read (`req_is_fetch`=0) inside a window returns the overlay word when the global enable and the requesting core's bit 1 are both set.
- R6: An instruction fetch (`req_is_fetch`=1) inside a window returns 0xE59FF000 when the global enable and the requesting core's bit 0 are both set.
- R7: When the global enable is clear, every request returns `rom_rdata` unchanged, even if the boot bits are set.
- R8: The windows are 0xFFFF0000–0xFFFF0FFF and 0x00010000–0x00010FFF, inclusive. Addresses just outside them, such as 0xFFFEFFFF, 0xFFFF1000, 0x0000FFFF and 0x00011000, return `rom_rdata`.
- R9: A core's boot bits affect only that core's requests.
- R10: The data-override bit has no effect on fetches, and the fetch-override bit has no effect on data reads.
- R11: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high. `rsp_data` is the result for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the selected register |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Read address |
| req_is_fetch | input | 1 | 1 = instruction fetch, 0 = data read |
| req_core | input | 2 | Requesting core number |
| rom_rdata | input | 32 | ROM word for the current request |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 32 | Word returned to the core |

## Verification
The hardest case to reach is a request whose core, access type and window all line up with a configuration that enables exactly the opposite override, or the right override for a different core. With uniform random stimulus this is rare because addresses seldom land in the two small windows. The stimulus therefore draws most addresses from the windows and from the words just beside their edges. It also rewrites the boot registers at random between requests, so that every pairing of enable, fetch bit, data bit and core occurs many times.

// File: rtl/rom_overlay_pkg.sv
package rom_overlay_pkg;
  localparam logic [31:0] FETCH_WORD = 32'hE59FF000;
  typedef enum logic [2:0] {
    CFG_CTRL  = 3'd0,
    CFG_VALUE = 3'd1,
    CFG_BOOT0 = 3'd4
  } cfg_sel_e;
  typedef struct packed {
    logic data_ov;
    logic fetch_ov;
  } boot_bits_t;
endpackage

// File: rtl/rom_overlay_cfg.sv
module rom_overlay_cfg
  import rom_overlay_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_CORES = 4,
  parameter int CFG_AW    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CFG_AW-1:0]      cfg_addr,
  input  logic [DATA_W-1:0]      cfg_wdata,
  output logic [DATA_W-1:0]      cfg_rdata,
  output logic                   glb_en,
  output logic [DATA_W-1:0]      ov_value,
  output boot_bits_t             boot [NUM_CORES]
);
  localparam int BOOT_BASE = int'(CFG_BOOT0);

  logic              en_q, en_d;
  logic [DATA_W-1:0] val_q, val_d;
  boot_bits_t        boot_q [NUM_CORES];
  logic [DATA_W-1:0] boot_rd [NUM_CORES];

  always_comb begin
    en_d  = en_q;
    val_d = val_q;
    if (cfg_we && cfg_addr == CFG_AW'(CFG_CTRL))  en_d  = cfg_wdata[0];
    if (cfg_we && cfg_addr == CFG_AW'(CFG_VALUE)) val_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      val_q <= '0;
    end else begin
      en_q  <= en_d;
      val_q <= val_d;
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic       sel;
    boot_bits_t nxt;
    assign sel = (cfg_addr == CFG_AW'(BOOT_BASE + c));
    always_comb begin
      nxt = boot_q[c];
      if (cfg_we && sel) nxt = '{data_ov: cfg_wdata[1], fetch_ov: cfg_wdata[0]};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) boot_q[c] <= '0;
      else        boot_q[c] <= nxt;
    end
    assign boot_rd[c] = sel ? {{(DATA_W-2){1'b0}}, boot_q[c].data_ov, boot_q[c].fetch_ov}
                            : '0;
    assign boot[c] = boot_q[c];
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == CFG_AW'(CFG_CTRL))  cfg_rdata = {{(DATA_W-1){1'b0}}, en_q};
    if (cfg_addr == CFG_AW'(CFG_VALUE)) cfg_rdata = val_q;
    for (int c = 0; c < NUM_CORES; c++) cfg_rdata = cfg_rdata | boot_rd[c];
  end

  assign glb_en   = en_q;
  assign ov_value = val_q;
endmodule

// File: rtl/rom_overlay_win.sv
module rom_overlay_win #(
  parameter int                       ADDR_W    = 32,
  parameter int                       NUM_WIN   = 2,
  parameter int                       WIN_BITS  = 12,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASES = {32'h0001_0000, 32'hFFFF_0000}
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - WIN_BITS;
  logic [NUM_WIN-1:0] match;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE = WIN_BASES[w*ADDR_W +: ADDR_W];
    assign match[w] = (addr[ADDR_W-1 -: TAG_W] == BASE[ADDR_W-1 -: TAG_W]);
  end

  assign hit = |match;
endmodule

// File: rtl/rom_overlay.sv
module rom_overlay
  import rom_overlay_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_CORES = 4,
  parameter int CFG_AW    = 3,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_fetch,
  input  logic [CORE_W-1:0] req_core,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic              glb_en;
  logic [DATA_W-1:0] ov_value;
  boot_bits_t        boot [NUM_CORES];
  boot_bits_t        cur;
  logic              win_hit;
  logic              use_val, use_fetch;
  logic              vld_d;
  logic [DATA_W-1:0] data_d;

  rom_overlay_cfg #(.DATA_W(DATA_W), .NUM_CORES(NUM_CORES), .CFG_AW(CFG_AW)) u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .glb_en, .ov_value, .boot
  );

  rom_overlay_win #(.ADDR_W(ADDR_W)) u_win (.addr(req_addr), .hit(win_hit));

  assign cur       = boot[req_core];
  assign use_val   = glb_en && win_hit && !req_is_fetch && cur.data_ov;
  assign use_fetch = glb_en && win_hit &&  req_is_fetch && cur.fetch_ov;

  always_comb begin
    vld_d  = req_valid;
    data_d = rsp_data;
    if (req_valid) begin
      if (use_val)        data_d = ov_value;
      else if (use_fetch) data_d = DATA_W'(FETCH_WORD);
      else                data_d = rom_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= vld_d;
      rsp_data  <= data_d;
    end
  end
endmodule

// File: rtl/rom_overlay_chk.sv
module rom_overlay_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CFG_AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              req_valid,
  input logic              glb_en,
  input logic              win_hit,
  input logic [DATA_W-1:0] rom_rdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data
);
  // R11: a response follows each request after exactly one cycle
  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R7: overlay disabled passes ROM data through
  p_disabled_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !glb_en) |=> rsp_data == $past(rom_rdata));
  // R8: addresses outside the windows pass ROM data through
  p_outside_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !win_hit) |=> rsp_data == $past(rom_rdata));
  // R2: control register upper bits read zero
  p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == '0) |-> cfg_rdata[DATA_W-1:1] == '0);
endmodule

bind rom_overlay rom_overlay_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_AW(CFG_AW)) u_chk (
  .clk, .rst_n, .cfg_addr, .cfg_rdata, .req_valid,
  .glb_en(glb_en), .win_hit(win_hit), .rom_rdata, .rsp_valid, .rsp_data
);

// File: tb/tb_rom_overlay.sv
module tb_rom_overlay;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        req_valid, req_is_fetch;
  logic [31:0] req_addr, rom_rdata;
  logic [1:0]  req_core;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int vectors = 0, errors = 0;
  logic        m_en;
  logic [31:0] m_val;
  logic [1:0]  m_boot [4];

  always #4 clk = ~clk;

  rom_overlay dut (.*);

  function automatic bit in_win(logic [31:0] a);
    return (a[31:12] == 20'hFFFF0) || (a[31:12] == 20'h00010);
  endfunction

  function automatic logic [31:0] exp_rsp(logic [31:0] a, logic f, logic [1:0] c, logic [31:0] rom);
    if (m_en && in_win(a) && !f && m_boot[c][1]) return m_val;
    if (m_en && in_win(a) &&  f && m_boot[c][0]) return 32'hE59FF000;
    return rom;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 3'd0) m_en = d[0];
    if (a == 3'd1) m_val = d;
    if (a >= 3'd4) m_boot[a-3'd4] = d[1:0];
  endtask

  task automatic rdchk(string req, logic [2:0] a, logic [31:0] exp);
    cfg_addr = a; #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic rq(string req, logic [31:0] a, logic f, logic [1:0] c, logic [31:0] rom);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_is_fetch = f; req_core = c; rom_rdata = rom;
    @(negedge clk);
    req_valid = 1'b0; rom_rdata = ~rom;
    check({req, " valid R11"}, {31'd0, rsp_valid}, 32'd1);
    check(req, rsp_data, exp_rsp(a, f, c, rom));
  endtask

  function automatic logic [31:0] pick_addr();
    case ($urandom_range(0, 5))
      0: return 32'hFFFF0000 | $urandom_range(0, 32'hFFF);
      1: return 32'h00010000 | $urandom_range(0, 32'hFFF);
      2: return ($urandom_range(0, 1) != 0) ? 32'hFFFEFFFF : 32'hFFFF1000;
      3: return ($urandom_range(0, 1) != 0) ? 32'h0000FFFF : 32'h00011000;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_en = 1'b0; m_val = '0;
    for (int i = 0; i < 4; i++) m_boot[i] = 2'b00;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_is_fetch = 1'b0; req_core = '0; rom_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < 8; a++) rdchk("R1 reset readback", 3'(a), 32'd0);
    check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);

    // R2, R3, R4 readback
    wr(3'd0, 32'hFFFF_FFFE); rdchk("R2 ctrl bit0 clear", 3'd0, 32'd0);
    wr(3'd0, 32'hA5A5_A5A5); rdchk("R2 ctrl upper zero", 3'd0, 32'd1);
    wr(3'd1, 32'hDEAD_BEEF); rdchk("R3 value", 3'd1, 32'hDEADBEEF);
    wr(3'd5, 32'hFFFF_FFFF); rdchk("R4 boot1 bits", 3'd5, 32'd3);
    wr(3'd2, 32'hFFFF_FFFF); rdchk("R4 hole addr 2", 3'd2, 32'd0);
    wr(3'd3, 32'hFFFF_FFFF); rdchk("R4 hole addr 3", 3'd3, 32'd0);
    rdchk("R4 boot0 untouched", 3'd4, 32'd0);

    // R5, R6 on core 1; R9 core 0 unaffected
    rq("R5 data override", 32'hFFFF0010, 1'b0, 2'd1, 32'h11111111);
    rq("R6 fetch override", 32'h00010FFC, 1'b1, 2'd1, 32'h22222222);
    rq("R9 other core data", 32'hFFFF0010, 1'b0, 2'd0, 32'h33333333);
    rq("R9 other core fetch", 32'h00010000, 1'b1, 2'd2, 32'h44444444);
    // R8 boundaries
    rq("R8 below win0", 32'hFFFEFFFF, 1'b0, 2'd1, 32'h55555555);
    rq("R8 above win0", 32'hFFFF1000, 1'b1, 2'd1, 32'h66666666);
    rq("R8 below win1", 32'h0000FFFF, 1'b0, 2'd1, 32'h77777777);
    rq("R8 above win1", 32'h00011000, 1'b1, 2'd1, 32'h88888888);
    rq("R8 win0 last", 32'hFFFF0FFF, 1'b0, 2'd1, 32'h99999999);
    // R10 cross-independence
    wr(3'd6, 32'd2);
    rq("R10 data bit no fetch", 32'hFFFF0000, 1'b1, 2'd2, 32'hAAAA0000);
    rq("R5 data bit core2", 32'hFFFF0000, 1'b0, 2'd2, 32'hAAAA0001);
    wr(3'd7, 32'd1);
    rq("R10 fetch bit no data", 32'h00010004, 1'b0, 2'd3, 32'hBBBB0000);
    rq("R6 fetch bit core3", 32'h00010004, 1'b1, 2'd3, 32'hBBBB0001);
    // R7 global disable
    wr(3'd0, 32'd0);
    rq("R7 disabled data", 32'hFFFF0010, 1'b0, 2'd1, 32'hCCCC0000);
    rq("R7 disabled fetch", 32'hFFFF0010, 1'b1, 2'd1, 32'hCCCC0001);
    // R11 idle cycle
    @(negedge clk);
    check("R11 idle no valid", {31'd0, rsp_valid}, 32'd0);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        case ($urandom_range(0, 2))
          0: wr(3'd0, $urandom());
          1: wr(3'd1, $urandom());
          default: wr(3'(4 + $urandom_range(0, 3)), $urandom());
        endcase
      end
      rq("R5/R6/R7/R8/R9/R10 random", pick_addr(), 1'($urandom_range(0, 1)),
         2'($urandom_range(0, 3)), $urandom());
    end
    for (int a = 0; a < 8; a++) begin
      logic [31:0] e;
      e = (a == 0) ? {31'd0, m_en} : (a == 1) ? m_val : (a >= 4) ? {30'd0, m_boot[a-4]} : 32'd0;
      rdchk("R2/R3/R4 final readback", 3'(a), e);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule